// File: doc/BRIEF.md
# Split-Bank DRAM Command Legality Checker

This block sits beside a DRAM command bus and judges every command as it goes by. The device it watches has 32 banks whose sense amplifiers are shared between neighbouring banks. The block keeps, for every bank, whether a row is open and how many cycles have passed since the last activate and the last precharge. It also remembers the most recent row packet on the bus. When a command breaks a bank-state rule, the neighbour-sharing rule or a minimum spacing, the block raises a one-cycle error pulse together with a code naming the rule.

Time is counted in packet cycles, with one command slot per clock. The minimum intervals are parameters: row-to-column delay, active time, precharge time and row-packet spacing. The device the block checks is also chosen by parameter. Commands addressed to other devices take part only in the row-packet spacing rule. The row address does not affect legality, so the command port carries no row field. A command that is flagged leaves the bank state untouched, so checking continues cleanly on the commands that follow.

Opcodes on `cmd_op` are: 0 = activate, 1 = precharge, 2 = read, 3 = write. Activate and precharge are row packets; read and write are column packets.

Top module: `sbank_cmd_checker`

## Requirements
- R1: After reset, no error is reported, every bank is precharged, and every interval is treated as long expired, so an activate to any bank right after reset is legal.
- R2: The verdict for a command presented with `cmd_valid` high in cycle n appears on `err_pulse`/`err_code` in cycle n+1. `err_code` is 0 whenever `err_pulse` is low and nonzero whenever it is high.
- R3: The following are state errors, reported as code 1 for the checked device: an activate to a bank that is already open, and a read, write or precharge to a precharged bank.
- R4: An activate to bank b while bank b-1 or b+1 is open is a neighbour error (code 2). Banks 15 and 16 are not neighbours. Bank 0 has only bank 1 as a neighbour, and bank 31 has only bank 30.
- R5: A read or write issued fewer than T_RCD cycles after the activate of its bank is reported as code 3.
- R6: A precharge issued fewer than T_RAS cycles after the activate of its bank is reported as code 4.
- R7: An activate issued fewer than T_RP cycles after the precharge of its bank is reported as code 5.
- R8: A row packet that arrives fewer than T_PP cycles after the most recent row packet is a spacing error (code 6) when both carry the same device field and they target the same bank, neighbouring banks, or both are the same opcode. In every other case row packets may follow back to back.
- R9: A command whose device field differs from DEV_ID never changes any bank state. It can only raise a spacing error (code 6), and column commands to another device are never flagged.
- R10: When several rules are broken at once, exactly one code is reported, chosen in this order: state, neighbour, interval (codes 3/4/5), spacing.
- R11: A flagged command leaves all bank state and bank timers unchanged. A flagged row packet still counts as the most recent row packet for R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Opcode: 0 activate, 1 precharge, 2 read, 3 write |
| cmd_dev | input | DEV_W (5) | Device field of the command |
| cmd_bank | input | log2(NUM_BANKS) (5) | Bank field of the command |
| err_pulse | output | 1 | High for one cycle when the previous command broke a rule |
| err_code | output | 3 | Rule broken (R3 to R8 codes), 0 when none |

## Verification
The assertions assume that `cmd_op`, `cmd_dev` and `cmd_bank` carry known values whenever `cmd_valid` is high, and that at most one command arrives per cycle. They also assume that the device under check never has two neighbouring banks open, an invariant that follows from the block's own accept rule. The stimulus always drives defined fields, including in idle cycles. It mixes a directed walk through every rule and boundary bank with a long stream of random commands, mostly addressed to the checked device, so that the neighbour and spacing rules fire often without ever feeding undefined values.

// File: rtl/sbc_pkg.sv
// Shared types and helpers for the split-bank command checker.
// Assumes banks are split into two equal halves whose facing edge banks
// do not share a sense amplifier.
package sbc_pkg;

    typedef enum logic [1:0] {
        OP_ACT  = 2'd0,
        OP_PRER = 2'd1,
        OP_RD   = 2'd2,
        OP_WR   = 2'd3
    } sbc_op_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_STATE = 3'd1,
        ERR_NBR   = 3'd2,
        ERR_TRCD  = 3'd3,
        ERR_TRAS  = 3'd4,
        ERR_TRP   = 3'd5,
        ERR_TPP   = 3'd6
    } sbc_err_e;

    // True when banks a and b share a sense amplifier (adjacent, same half).
    function automatic logic sbc_adjacent(input int a, input int b, input int half);
        return ((a == b + 1) || (b == a + 1)) && ((a / half) == (b / half));
    endfunction

endpackage

// File: rtl/sbc_age_counter.sv
// Saturating age counter: counts cycles since the last restart.
// Reset loads the saturated value so that any interval reads as expired.
// A restart makes the count read 1 in the following cycle.
module sbc_age_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] AGE_MAX = '1;

    // Restart, or advance until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= AGE_MAX;
        else if (restart)
            age <= W'(1);
        else if (age != AGE_MAX)
            age <= age + W'(1);
    end
endmodule

// File: rtl/sbc_bank_slot.sv
// State of one bank: open flag plus the age of its last activate and
// last precharge. Assumes the caller only requests legal transitions.
module sbc_bank_slot #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_open,
    input  logic             do_close,
    output logic             is_open,
    output logic [CNT_W-1:0] act_age,
    output logic [CNT_W-1:0] pre_age
);
    // Open flag follows accepted activate and precharge commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (do_open)
            is_open <= 1'b1;
        else if (do_close)
            is_open <= 1'b0;
    end

    sbc_age_counter #(.W(CNT_W)) u_act_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_open),
        .age     (act_age)
    );

    sbc_age_counter #(.W(CNT_W)) u_pre_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_close),
        .age     (pre_age)
    );
endmodule

// File: rtl/sbc_pp_tracker.sv
// Remembers the most recent row packet on the bus (any device) and flags
// a new row packet that comes too soon after it. Assumes at most one
// command per cycle. The spacing window is measured with a saturating age.
module sbc_pp_tracker
    import sbc_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 5,
    parameter int HALF   = 16,
    parameter int T_PP   = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic [DEV_W-1:0]  dev,
    input  logic [BANK_W-1:0] bank,
    input  logic              is_act,
    output logic              conflict
);
    logic [DEV_W-1:0]  last_dev;
    logic [BANK_W-1:0] last_bank;
    logic              last_act;
    logic [CNT_W-1:0]  since;
    logic              same_target;

    // Capture the fields of every row packet seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_dev  <= '0;
            last_bank <= '0;
            last_act  <= 1'b0;
        end else if (row_valid) begin
            last_dev  <= dev;
            last_bank <= bank;
            last_act  <= is_act;
        end
    end

    sbc_age_counter #(.W(CNT_W)) u_since (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (row_valid),
        .age     (since)
    );

    // Decide whether the new packet is tied to the previous one.
    always_comb begin
        same_target = (bank == last_bank)
                   || sbc_adjacent(int'(bank), int'(last_bank), HALF)
                   || (is_act == last_act);
        conflict = row_valid && (since < CNT_W'(T_PP))
                && (dev == last_dev) && same_target;
    end
endmodule

// File: rtl/sbank_cmd_checker.sv
// Split-bank DRAM command legality checker (top).
// Watches one command per cycle, checks it against the per-bank state,
// the neighbour-sharing rule and the minimum intervals, and reports the
// verdict one cycle later. Assumes NUM_BANKS is a power of two and that
// fields are defined whenever cmd_valid is high.
module sbank_cmd_checker
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int DEV_W     = 5,
    parameter int DEV_ID    = 0,
    parameter int T_RCD     = 7,
    parameter int T_RAS     = 20,
    parameter int T_RP      = 8,
    parameter int T_PP      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [DEV_W-1:0]              cmd_dev,
    input  logic [$clog2(NUM_BANKS)-1:0]  cmd_bank,
    output logic                          err_pulse,
    output logic [2:0]                    err_code
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int HALF   = NUM_BANKS / 2;
    localparam int T_M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int T_M2   = (T_RP > T_PP) ? T_RP : T_PP;
    localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] do_open;
    logic [NUM_BANKS-1:0] do_close;
    logic [CNT_W-1:0]     act_age [NUM_BANKS];
    logic [CNT_W-1:0]     pre_age [NUM_BANKS];

    logic     own_dev;
    logic     row_pkt;
    logic     pp_conflict;
    logic     nbr_open;
    logic     sel_open;
    logic [CNT_W-1:0] sel_act_age;
    logic [CNT_W-1:0] sel_pre_age;
    sbc_err_e verdict;
    sbc_op_e  op;

    assign op      = sbc_op_e'(cmd_op);
    assign own_dev = (cmd_dev == DEV_W'(DEV_ID));
    assign row_pkt = cmd_valid && ((op == OP_ACT) || (op == OP_PRER));

    // One state slot per bank; a slot changes only on an accepted command.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign do_open[g]  = cmd_valid && own_dev && (op == OP_ACT)
                          && (cmd_bank == BANK_W'(g)) && (verdict == ERR_NONE);
        assign do_close[g] = cmd_valid && own_dev && (op == OP_PRER)
                          && (cmd_bank == BANK_W'(g)) && (verdict == ERR_NONE);

        sbc_bank_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_open  (do_open[g]),
            .do_close (do_close[g]),
            .is_open  (open_vec[g]),
            .act_age  (act_age[g]),
            .pre_age  (pre_age[g])
        );
    end

    sbc_pp_tracker #(
        .DEV_W  (DEV_W),
        .BANK_W (BANK_W),
        .HALF   (HALF),
        .T_PP   (T_PP),
        .CNT_W  (CNT_W)
    ) u_pp (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_pkt),
        .dev       (cmd_dev),
        .bank      (cmd_bank),
        .is_act    (op == OP_ACT),
        .conflict  (pp_conflict)
    );

    // Select the addressed bank and look for an open neighbour.
    always_comb begin
        sel_open    = open_vec[cmd_bank];
        sel_act_age = act_age[cmd_bank];
        sel_pre_age = pre_age[cmd_bank];
        nbr_open    = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (open_vec[b] && sbc_adjacent(b, int'(cmd_bank), HALF))
                nbr_open = 1'b1;
        end
    end

    // Apply the rules in priority order: state, neighbour, interval, spacing.
    always_comb begin
        verdict = ERR_NONE;
        if (cmd_valid) begin
            if (own_dev) begin
                unique case (op)
                    OP_ACT: begin
                        if (sel_open)                          verdict = ERR_STATE;
                        else if (nbr_open)                     verdict = ERR_NBR;
                        else if (sel_pre_age < CNT_W'(T_RP))   verdict = ERR_TRP;
                        else if (pp_conflict)                  verdict = ERR_TPP;
                    end
                    OP_PRER: begin
                        if (!sel_open)                         verdict = ERR_STATE;
                        else if (sel_act_age < CNT_W'(T_RAS))  verdict = ERR_TRAS;
                        else if (pp_conflict)                  verdict = ERR_TPP;
                    end
                    default: begin
                        if (!sel_open)                         verdict = ERR_STATE;
                        else if (sel_act_age < CNT_W'(T_RCD))  verdict = ERR_TRCD;
                    end
                endcase
            end else if (pp_conflict) begin
                verdict = ERR_TPP;
            end
        end
    end

    // Register the verdict so it appears in the cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_pulse <= (verdict != ERR_NONE);
            err_code  <= verdict;
        end
    end
endmodule

// File: rtl/sbc_checker.sv
// Property checker for the split-bank command checker, bound to the top.
// Assumes command fields are defined whenever cmd_valid is high.
module sbc_checker
    import sbc_pkg::*;
#(
    parameter int NUM_BANKS = 32,
    parameter int DEV_W     = 5,
    parameter int DEV_ID    = 0
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_valid,
    input logic [1:0]                   cmd_op,
    input logic [DEV_W-1:0]             cmd_dev,
    input logic                         err_pulse,
    input logic [2:0]                   err_code,
    input logic [NUM_BANKS-1:0]         open_vec
);
    localparam int HALF = NUM_BANKS / 2;

    logic twin_open;

    // Detect two open banks that share a sense amplifier.
    always_comb begin
        twin_open = 1'b0;
        for (int b = 0; b + 1 < NUM_BANKS; b++) begin
            if (open_vec[b] && open_vec[b+1] && sbc_adjacent(b, b + 1, HALF))
                twin_open = 1'b1;
        end
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !err_pulse);

    // R2
    code_matches_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_code != 3'd0));

    // R2
    pulse_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(cmd_valid));

    // R4
    no_twin_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !twin_open);

    // R5
    column_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && $past(cmd_op[1])) |-> (err_code == ERR_STATE || err_code == ERR_TRCD));

    // R6
    row_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !$past(cmd_op[1])) |-> (err_code != ERR_TRCD));

    // R9
    foreign_spacing_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && ($past(cmd_dev) != DEV_W'(DEV_ID))) |-> (err_code == ERR_TPP));
endmodule

bind sbank_cmd_checker sbc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .DEV_W     (DEV_W),
    .DEV_ID    (DEV_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dev   (cmd_dev),
    .err_pulse (err_pulse),
    .err_code  (err_code),
    .open_vec  (open_vec)
);

// File: tb/sbank_cmd_checker_tb.sv
// Bench: behavioural reference model compared against the design each cycle.
module sbank_cmd_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 32;
    localparam int TRCD = 7;
    localparam int TRAS = 20;
    localparam int TRP  = 8;
    localparam int TPP  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [4:0] cmd_dev = 5'd0;
    logic [4:0] cmd_bank = 5'd0;
    logic       err_pulse;
    logic [2:0] err_code;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    int m_open [NB];
    int m_act  [NB];
    int m_pre  [NB];
    int lr_t, lr_dev, lr_bank, lr_op;
    int now;
    int exp_code;
    bit have_prev;
    string exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbank_cmd_checker #(
        .NUM_BANKS (NB), .DEV_W (5), .DEV_ID (0),
        .T_RCD (TRCD), .T_RAS (TRAS), .T_RP (TRP), .T_PP (TPP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_dev (cmd_dev), .cmd_bank (cmd_bank),
        .err_pulse (err_pulse), .err_code (err_code)
    );

    function automatic bit shares(int a, int b);
        if (a / 16 != b / 16) return 0;
        return (a - b == 1) || (b - a == 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, now);
        end
    endtask

    task automatic compare_prev();
        if (have_prev) begin
            check(err_code == 3'(exp_code), exp_tag, int'(err_code), exp_code);
            check(err_pulse == (exp_code != 0), exp_tag, int'(err_pulse), int'(exp_code != 0));
        end
    endtask

    // Model: decide the verdict for a command at time now, then update.
    task automatic model(bit v, int op, int dev, int bank);
        bit row, pp, nbr;
        int code;
        code = 0;
        row  = (op < 2);
        pp   = v && row && (now - lr_t < TPP) && (dev == lr_dev)
            && (bank == lr_bank || shares(bank, lr_bank) || op == lr_op);
        nbr = 0;
        for (int j = 0; j < NB; j++) if (m_open[j] != 0 && shares(j, bank)) nbr = 1;
        if (v) begin
            if (dev == 0) begin
                if (op == 0) begin
                    if (m_open[bank] != 0)            code = 1;
                    else if (nbr)                     code = 2;
                    else if (now - m_pre[bank] < TRP) code = 5;
                    else if (pp)                      code = 6;
                end else if (op == 1) begin
                    if (m_open[bank] == 0)             code = 1;
                    else if (now - m_act[bank] < TRAS) code = 4;
                    else if (pp)                       code = 6;
                end else begin
                    if (m_open[bank] == 0)             code = 1;
                    else if (now - m_act[bank] < TRCD) code = 3;
                end
            end else if (pp) code = 6;
        end
        if (v && row) begin
            lr_t = now; lr_dev = dev; lr_bank = bank; lr_op = op;
        end
        if (v && dev == 0 && code == 0) begin
            if (op == 0) begin m_open[bank] = 1; m_act[bank] = now; end
            if (op == 1) begin m_open[bank] = 0; m_pre[bank] = now; end
        end
        exp_code = code;
    endtask

    task automatic issue(bit v, int op, int dev, int bank, string tag);
        @(negedge clk);
        compare_prev();
        cmd_valid = v;
        cmd_op    = 2'(op);
        cmd_dev   = 5'(dev);
        cmd_bank  = 5'(bank);
        model(v, op, dev, bank);
        exp_tag   = tag;
        have_prev = 1;
        now++;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) issue(0, 0, 0, 0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act[b] = -1000; m_pre[b] = -1000;
        end
        lr_t = -1000; lr_dev = 0; lr_bank = 0; lr_op = 0;
        now = 0; exp_code = 0; have_prev = 0; exp_tag = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(err_pulse == 1'b0, "R1", int'(err_pulse), 0);
        check(err_code == 3'd0, "R1", int'(err_code), 0);

        issue(1, 0, 0, 5, "R1");    // activate right after reset is legal
        issue(1, 2, 0, 5, "R5");    // read too soon
        issue(1, 0, 0, 4, "R4");    // neighbour open, also too close (R10)
        issue(1, 0, 0, 6, "R4");
        idle(6, "R2");
        issue(1, 3, 0, 5, "R5");    // write after tRCD: clean
        issue(1, 1, 0, 5, "R6");    // precharge before tRAS
        issue(1, 0, 0, 5, "R3");    // activate an open bank
        issue(1, 2, 0, 9, "R3");    // read a precharged bank
        issue(1, 1, 0, 9, "R3");    // precharge a precharged bank
        idle(4, "R2");
        issue(1, 0, 0, 15, "R4");
        idle(4, "R2");
        issue(1, 0, 0, 16, "R4");   // 15 and 16 not neighbours
        idle(4, "R2");
        issue(1, 0, 0, 31, "R4");
        idle(4, "R2");
        issue(1, 0, 0, 0, "R4");
        idle(4, "R2");
        issue(1, 0, 0, 1, "R4");    // neighbour of open bank 0
        idle(4, "R2");
        issue(1, 0, 3, 5, "R9");    // foreign device, no bank effect
        issue(1, 0, 3, 20, "R9");   // foreign spacing conflict
        issue(1, 0, 0, 20, "R11");  // different device from last row: clean
        issue(1, 0, 0, 22, "R8");   // same opcode back to back
        idle(4, "R2");
        issue(1, 0, 0, 10, "R8");
        issue(1, 1, 0, 5, "R8");    // other opcode, far bank: allowed
        issue(1, 0, 0, 5, "R7");    // activate before tRP
        idle(TRP, "R2");
        issue(1, 0, 0, 5, "R7");
        idle(TRAS, "R2");
        issue(1, 1, 0, 5, "R11");   // bank 5 survived earlier errors
        issue(1, 1, 0, 6, "R10");   // state error wins over spacing

        for (int i = 0; i < 3000; i++) begin
            int v, op, dev, bank;
            v    = ($urandom % 10) < 7;
            op   = $urandom % 4;
            dev  = (($urandom % 8) == 0) ? 1 : 0;
            bank = $urandom % NB;
            issue(v[0], op, dev, bank, "R2/R10");
        end
        idle(2, "R2");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule